// File: doc/BRIEF.md
# Branch Trace Record Store Controller

This block turns a stream of taken-branch events into fixed-size trace records in a memory buffer. Each event brings a source address, a target address and a two-bit privilege level. Control inputs decide four things. The first is whether branch messages are produced at all. The second is whether those messages are stored. The third is which privilege levels are stored. The fourth is what happens as the buffer fills: the write index either wraps back to the base, or the block stops at the top of the buffer.

Software sets the buffer geometry through configuration inputs: a base address, an exclusive upper limit and an interrupt threshold. It can also overwrite the current write index. Records are written through a single-word memory write port, one word per cycle. A single-cycle interrupt pulse reports that the index has reached the threshold.

Top module: `btrace_store`

## Requirements
- R1: While `ctl_trace_en` is 0, `msg_valid` stays low and no memory write is started, whatever the other controls are.
- R2: With `ctl_trace_en`=1, every cycle with `br_valid` high gives a `msg_valid` pulse exactly one cycle later. This happens whether or not the event is stored. With `ctl_store_en`=0, nothing is written.
- R3: With `ctl_skip_kernel`=1 and `ctl_skip_user`=0, only events with `br_priv` greater than 0 are stored.
- R4: With `ctl_skip_user`=1 and `ctl_skip_kernel`=0, only events with `br_priv` equal to 0 are stored.
- R5: With both skip bits set, no event is stored, in either buffer mode.
- R6: An accepted event produces three writes on consecutive cycles, starting the cycle after acceptance. The addresses are idx, idx+1 and idx+2. The words are, in order: the source address, the target address, and a flags word with bit DW-1 set, bits 1:0 holding the privilege level and all other bits 0. After the third write the index rises by 3.
- R7: In wrap mode (`ctl_irq_mode`=0), when the advanced index plus 3 would exceed `cfg_limit`, the index is set to `cfg_base` instead.
- R8: In interrupt mode (`ctl_irq_mode`=1), the index never wraps. An event is not stored when idx+3 exceeds `cfg_limit`, and the index is left unchanged.
- R9: `irq_pulse` is high for one cycle when a record completes and the new index is at least `cfg_thresh`. This holds in both modes. It then stays low until an index write below the threshold re-arms it. A threshold above the limit suppresses it.
- R10: `cfg_err` is high while `cfg_limit` is less than `cfg_base`+3. While it is high, no record is started.
- R11: An event that would be stored while a record is still being written is dropped without any write. It sets the sticky `ovf_flag`, which only reset clears.
- R12: Reset clears `cur_index`, `msg_valid`, `mem_we`, `irq_pulse` and `ovf_flag`. A cycle with `idx_wr_en` loads `idx_wr_data` into `cur_index`, visible the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_trace_en | input | 1 | Produce branch messages |
| ctl_store_en | input | 1 | Store messages in the buffer |
| ctl_skip_kernel | input | 1 | Do not store privilege-0 events |
| ctl_skip_user | input | 1 | Do not store privilege>0 events |
| ctl_irq_mode | input | 1 | 1: threshold interrupt, no wrap; 0: circular buffer |
| cfg_base | input | AW | Buffer base word address |
| cfg_limit | input | AW | Exclusive upper word address |
| cfg_thresh | input | AW | Interrupt threshold address |
| idx_wr_en | input | 1 | Overwrite the write index |
| idx_wr_data | input | AW | New index value |
| br_valid | input | 1 | Branch event strobe |
| br_from | input | DW | Source address |
| br_to | input | DW | Target address |
| br_priv | input | 2 | Privilege level |
| msg_valid | output | 1 | Branch message produced |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| irq_pulse | output | 1 | Threshold interrupt pulse |
| ovf_flag | output | 1 | Sticky dropped-event flag |
| cfg_err | output | 1 | Illegal buffer geometry |
| cur_index | output | AW | Current write index |

## Verification
The bench walks the index through a three-record buffer so that one record lands exactly on the limit. A design with an off-by-one wrap test would either overwrite past the limit or wrap one record early. It drives the threshold crossing several times: without a re-arm, after an index rewrite below the threshold, and with the threshold placed above the limit. A design that re-fires on every crossing, or that ignores the suppression, shows extra interrupt pulses. Back-to-back events probe the busy window: a design that accepts the second event would corrupt the address sequence and leave the overflow flag clear. The bench also covers a full buffer in interrupt mode and an illegal geometry. A design that mishandled either case would issue writes where none may occur.

// File: rtl/btr_pkg.sv
package btr_pkg;
  localparam int unsigned REC_WORDS = 3;

  typedef enum logic [1:0] {
    W_FROM  = 2'd0,
    W_TO    = 2'd1,
    W_FLAGS = 2'd2
  } word_sel_e;
endpackage

// File: rtl/btr_filter.sv
module btr_filter #(
  parameter int unsigned AW = 16
) (
  input  logic          trace_en,
  input  logic          store_en,
  input  logic          skip_kernel,
  input  logic          skip_user,
  input  logic          irq_mode,
  input  logic [1:0]    priv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [AW-1:0] idx,
  output logic          store_ok,
  output logic          geom_err
);
  import btr_pkg::*;

  localparam logic [AW:0] REC = (AW+1)'(REC_WORDS);

  logic [AW:0] base_end;
  logic [AW:0] idx_end;
  logic        priv_ok;
  logic        room_ok;

  always_comb begin
    base_end = {1'b0, base} + REC;
    idx_end  = {1'b0, idx} + REC;
    geom_err = {1'b0, limit} < base_end;
    room_ok  = !irq_mode || (idx_end <= {1'b0, limit});
    priv_ok  = (priv == 2'd0) ? !skip_kernel : !skip_user;
    store_ok = trace_en && store_en && priv_ok && !geom_err && room_ok;
  end
endmodule

// File: rtl/btr_writer.sv
module btr_writer #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic          store_ok,
  input  logic [DW-1:0] ev_from,
  input  logic [DW-1:0] ev_to,
  input  logic [1:0]    ev_priv,
  input  logic [AW-1:0] idx,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rec_done,
  output logic          drop_flag
);
  import btr_pkg::*;

  logic            busy_q,  busy_d;
  word_sel_e       sel_q,   sel_d;
  logic [DW-1:0]   from_q,  from_d;
  logic [DW-1:0]   to_q,    to_d;
  logic [1:0]      priv_q,  priv_d;
  logic [AW-1:0]   start_q, start_d;
  logic            drop_q,  drop_d;
  logic            accept;
  logic            collide;

  always_comb begin
    accept  = ev_valid && store_ok && !busy_q;
    collide = ev_valid && store_ok && busy_q;
    busy_d  = busy_q;
    sel_d   = sel_q;
    from_d  = from_q;
    to_d    = to_q;
    priv_d  = priv_q;
    start_d = start_q;
    drop_d  = drop_q || collide;
    if (accept) begin
      busy_d  = 1'b1;
      sel_d   = W_FROM;
      from_d  = ev_from;
      to_d    = ev_to;
      priv_d  = ev_priv;
      start_d = idx;
    end else if (busy_q) begin
      if (sel_q == W_FLAGS) busy_d = 1'b0;
      else                  sel_d  = word_sel_e'(sel_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sel_q   <= W_FROM;
      from_q  <= '0;
      to_q    <= '0;
      priv_q  <= '0;
      start_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      sel_q   <= sel_d;
      from_q  <= from_d;
      to_q    <= to_d;
      priv_q  <= priv_d;
      start_q <= start_d;
      drop_q  <= drop_d;
    end
  end

  always_comb begin
    wr_en    = busy_q;
    wr_addr  = start_q + AW'(sel_q);
    rec_done = busy_q && (sel_q == W_FLAGS);
    unique case (sel_q)
      W_FROM:  wr_data = from_q;
      W_TO:    wr_data = to_q;
      default: wr_data = {1'b1, {(DW-3){1'b0}}, priv_q};
    endcase
  end

  assign drop_flag = drop_q;
endmodule

// File: rtl/btr_index.sv
module btr_index #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          rec_done,
  input  logic          irq_mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [AW-1:0] thresh,
  output logic [AW-1:0] idx,
  output logic          irq
);
  import btr_pkg::*;

  localparam logic [AW:0] REC = (AW+1)'(REC_WORDS);

  logic [AW-1:0] idx_q, idx_d;
  logic          armed_q, armed_d;
  logic          irq_q, irq_d;
  logic [AW:0]   step;
  logic [AW-1:0] adv;

  always_comb begin
    step    = {1'b0, idx_q} + REC;
    adv     = step[AW-1:0];
    if (!irq_mode && ((step + REC) > {1'b0, limit})) adv = base;
    idx_d   = idx_q;
    armed_d = armed_q;
    irq_d   = 1'b0;
    if (wr_en) begin
      idx_d = wr_data;
      if (wr_data < thresh) armed_d = 1'b1;
    end else if (rec_done) begin
      idx_d = adv;
      if (armed_q && (adv >= thresh)) begin
        irq_d   = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign idx = idx_q;
  assign irq = irq_q;
endmodule

// File: rtl/btrace_store.sv
module btrace_store #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_trace_en,
  input  logic          ctl_store_en,
  input  logic          ctl_skip_kernel,
  input  logic          ctl_skip_user,
  input  logic          ctl_irq_mode,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic [AW-1:0] cfg_thresh,
  input  logic          idx_wr_en,
  input  logic [AW-1:0] idx_wr_data,
  input  logic          br_valid,
  input  logic [DW-1:0] br_from,
  input  logic [DW-1:0] br_to,
  input  logic [1:0]    br_priv,
  output logic          msg_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          irq_pulse,
  output logic          ovf_flag,
  output logic          cfg_err,
  output logic [AW-1:0] cur_index
);
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  logic       msg_q, msg_d;
  logic       store_ok;
  logic       rec_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  always_comb msg_d = ctl_trace_en && br_valid;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) msg_q <= 1'b0;
    else             msg_q <= msg_d;
  end
  assign msg_valid = msg_q;

  btr_filter #(.AW(AW)) u_filter (
    .trace_en    (ctl_trace_en),
    .store_en    (ctl_store_en),
    .skip_kernel (ctl_skip_kernel),
    .skip_user   (ctl_skip_user),
    .irq_mode    (ctl_irq_mode),
    .priv        (br_priv),
    .base        (cfg_base),
    .limit       (cfg_limit),
    .idx         (cur_index),
    .store_ok    (store_ok),
    .geom_err    (cfg_err)
  );

  btr_writer #(.AW(AW), .DW(DW)) u_writer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ev_valid  (br_valid),
    .store_ok  (store_ok),
    .ev_from   (br_from),
    .ev_to     (br_to),
    .ev_priv   (br_priv),
    .idx       (cur_index),
    .wr_en     (mem_we),
    .wr_addr   (mem_addr),
    .wr_data   (mem_wdata),
    .rec_done  (rec_done),
    .drop_flag (ovf_flag)
  );

  btr_index #(.AW(AW)) u_index (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (idx_wr_en),
    .wr_data  (idx_wr_data),
    .rec_done (rec_done),
    .irq_mode (ctl_irq_mode),
    .base     (cfg_base),
    .limit    (cfg_limit),
    .thresh   (cfg_thresh),
    .idx      (cur_index),
    .irq      (irq_pulse)
  );
endmodule

// File: rtl/btr_store_chk.sv
module btr_store_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          ctl_trace_en,
  input logic          ctl_store_en,
  input logic          msg_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          irq_pulse,
  input logic          ovf_flag,
  input logic          cfg_err
);
  // R1: no message follows a cycle with tracing off
  a_r1_no_msg: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ctl_trace_en |=> !msg_valid);

  // R2: storing disabled while idle means no write starts
  a_r2_no_store: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ctl_store_en && !mem_we) |=> !mem_we);

  // R6: words of one record go to consecutive addresses
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  // R6: a burst is never longer than three words
  a_r6_burst_len: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_we && $past(mem_we) && $past(mem_we, 2)) |=> !mem_we);

  // R9: interrupt lasts a single cycle
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_pulse |=> !irq_pulse);

  // R10: bad geometry while idle starts nothing
  a_r10_cfg_block: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_err && !mem_we) |=> !mem_we);

  // R11: overflow flag is sticky
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_core_n)
    ovf_flag |=> ovf_flag);
endmodule

bind btrace_store btr_store_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .ctl_trace_en (ctl_trace_en),
  .ctl_store_en (ctl_store_en),
  .msg_valid    (msg_valid),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .irq_pulse    (irq_pulse),
  .ovf_flag     (ovf_flag),
  .cfg_err      (cfg_err)
);

// File: tb/sim_btrace_store.sv
`timescale 1ns/1ps
module sim_btrace_store;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tr, se, skk, sku, mode;
  logic [AW-1:0] base, limit, thresh, iwd;
  logic          iw, bv;
  logic [DW-1:0] bfrom, bto;
  logic [1:0]    bpriv;
  logic          msg_valid, mem_we, irq_pulse, ovf_flag, cfg_err;
  logic [AW-1:0] mem_addr, cur_index;
  logic [DW-1:0] mem_wdata;

  always #5 clk = ~clk;

  btrace_store #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_trace_en(tr), .ctl_store_en(se), .ctl_skip_kernel(skk),
    .ctl_skip_user(sku), .ctl_irq_mode(mode),
    .cfg_base(base), .cfg_limit(limit), .cfg_thresh(thresh),
    .idx_wr_en(iw), .idx_wr_data(iwd),
    .br_valid(bv), .br_from(bfrom), .br_to(bto), .br_priv(bpriv),
    .msg_valid(msg_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq_pulse(irq_pulse), .ovf_flag(ovf_flag),
    .cfg_err(cfg_err), .cur_index(cur_index)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int  qa[$];
  longint qd[$];
  int  m_idx;
  bit  m_armed, m_irq, m_msg, m_ovf;
  bit  m_busy, m_done, m_st, m_pok;
  int  m_nx;

  always @(posedge clk) begin
    if (!rst_n) begin
      qa.delete(); qd.delete();
      m_idx = 0; m_armed = 1; m_irq = 0; m_msg = 0; m_ovf = 0;
    end else begin
      m_busy = (qa.size() != 0);
      m_done = (qa.size() == 1);
      m_pok  = (bpriv == 0) ? !skk : !sku;
      m_st   = tr && se && m_pok && !(int'(limit) < int'(base) + 3)
               && (!mode || (m_idx + 3 <= int'(limit)));
      m_msg  = tr && bv;
      if (m_busy) begin void'(qa.pop_front()); void'(qd.pop_front()); end
      if (bv && m_st) begin
        if (m_busy) m_ovf = 1;
        else begin
          qa.push_back(m_idx);     qd.push_back(longint'(bfrom));
          qa.push_back(m_idx + 1); qd.push_back(longint'(bto));
          qa.push_back(m_idx + 2); qd.push_back((64'h1 << (DW-1)) | longint'(bpriv));
        end
      end
      m_irq = 0;
      if (iw) begin
        m_idx = int'(iwd);
        if (int'(iwd) < int'(thresh)) m_armed = 1;
      end else if (m_done) begin
        m_nx = m_idx + 3;
        if (!mode && (m_nx + 3 > int'(limit))) m_nx = int'(base);
        m_idx = m_nx;
        if (m_armed && (m_nx >= int'(thresh))) begin m_irq = 1; m_armed = 0; end
      end
    end
  end

  int wr_cnt, msg_cnt, irq_cnt;
  int cap_a[$];
  longint cap_d[$];

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      check(mem_we == (qa.size() != 0), "R6 mem_we", mem_we, qa.size() != 0);
      if (qa.size() != 0) begin
        check(int'(mem_addr) == qa[0], "R6 mem_addr", mem_addr, qa[0]);
        check(longint'(mem_wdata) == qd[0], "R6 mem_wdata", mem_wdata, qd[0]);
      end
      check(msg_valid == m_msg, "R2 msg_valid", msg_valid, m_msg);
      check(irq_pulse == m_irq, "R9 irq_pulse", irq_pulse, m_irq);
      check(ovf_flag == m_ovf, "R11 ovf_flag", ovf_flag, m_ovf);
      check(int'(cur_index) == m_idx, "R7 cur_index", cur_index, m_idx);
      check(cfg_err == (int'(limit) < int'(base) + 3), "R10 cfg_err", cfg_err,
            int'(limit) < int'(base) + 3);
      if (mem_we) begin wr_cnt++; cap_a.push_back(int'(mem_addr)); cap_d.push_back(longint'(mem_wdata)); end
      if (msg_valid) msg_cnt++;
      if (irq_pulse) irq_cnt++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr;
    wr_cnt = 0; msg_cnt = 0; irq_cnt = 0; cap_a.delete(); cap_d.delete();
  endtask

  task automatic send(input logic [DW-1:0] f, input logic [DW-1:0] t, input logic [1:0] p);
    bv = 1; bfrom = f; bto = t; bpriv = p;
    @(negedge clk);
    bv = 0;
    idle(6);
  endtask

  task automatic set_idx(input logic [AW-1:0] v);
    iw = 1; iwd = v;
    @(negedge clk);
    iw = 0;
    idle(1);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; tr = 0; se = 0; skk = 0; sku = 0; mode = 0;
    base = 16'h100; limit = 16'h109; thresh = 16'h106;
    iw = 0; iwd = '0; bv = 0; bfrom = '0; bto = '0; bpriv = '0;
    idle(3);
    // R12 reset state
    check(cur_index == 0 && !mem_we && !msg_valid && !irq_pulse && !ovf_flag,
          "R12 reset", {cur_index, mem_we, msg_valid, irq_pulse, ovf_flag}, 0);
    @(negedge clk) rst_n = 1;
    idle(4);
    set_idx(16'h100);
    check(cur_index == 16'h100, "R12 index write", cur_index, 16'h100);

    clr(); send(32'hA0, 32'hB0, 2'd0);
    check(wr_cnt == 0 && msg_cnt == 0, "R1 trace off", {wr_cnt, msg_cnt}, 0);

    tr = 1; clr(); send(32'hA1, 32'hB1, 2'd3);
    check(msg_cnt == 1, "R2 message", msg_cnt, 1);
    check(wr_cnt == 0, "R2 no store", wr_cnt, 0);

    se = 1; skk = 1; clr();
    send(32'hA2, 32'hB2, 2'd0);
    send(32'hA3, 32'hB3, 2'd3);
    check(wr_cnt == 3, "R3 only priv>0", wr_cnt, 3);
    check(cap_a.size() == 3 && cap_a[0] == 'h100 && cap_a[2] == 'h102, "R6 addresses",
          cap_a.size() > 0 ? cap_a[0] : -1, 'h100);
    check(cap_d.size() == 3 && cap_d[0] == 'hA3 && cap_d[1] == 'hB3 && cap_d[2] == 64'h8000_0003,
          "R6 words", cap_d.size() == 3 ? cap_d[2] : -1, 64'h8000_0003);
    check(cur_index == 16'h103, "R6 index advance", cur_index, 16'h103);

    skk = 0; sku = 1; clr();
    send(32'hA4, 32'hB4, 2'd2);
    send(32'hA5, 32'hB5, 2'd0);
    check(wr_cnt == 3, "R4 only priv0", wr_cnt, 3);
    check(irq_cnt == 1, "R9 threshold pulse", irq_cnt, 1);

    skk = 1; clr();
    send(32'hA6, 32'hB6, 2'd0);
    send(32'hA7, 32'hB7, 2'd1);
    check(wr_cnt == 0 && msg_cnt == 2, "R5 both skipped", wr_cnt, 0);

    skk = 0; sku = 0; clr();
    send(32'hA8, 32'hB8, 2'd1);
    check(cur_index == 16'h100, "R7 wrap to base", cur_index, 16'h100);
    send(32'hA9, 32'hB9, 2'd1);
    send(32'hAA, 32'hBA, 2'd1);
    check(irq_cnt == 0, "R9 not re-armed", irq_cnt, 0);

    set_idx(16'h100); clr();
    send(32'hAB, 32'hBB, 2'd0);
    send(32'hAC, 32'hBC, 2'd0);
    check(irq_cnt == 1, "R9 re-armed", irq_cnt, 1);

    thresh = 16'h10C; set_idx(16'h100); clr();
    for (int i = 0; i < 3; i++) send(32'hC0 + i, 32'hD0 + i, 2'd1);
    check(irq_cnt == 0 && wr_cnt == 9, "R9 suppressed above limit", irq_cnt, 0);

    mode = 1; thresh = 16'h200; set_idx(16'h106); clr();
    send(32'hE0, 32'hF0, 2'd1);
    check(cur_index == 16'h109 && wr_cnt == 3, "R8 last record fits", cur_index, 16'h109);
    clr(); send(32'hE1, 32'hF1, 2'd1);
    check(wr_cnt == 0 && cur_index == 16'h109, "R8 full buffer", wr_cnt, 0);

    mode = 0; limit = 16'h101; set_idx(16'h100); clr();
    check(cfg_err == 1, "R10 flag", cfg_err, 1);
    send(32'hE2, 32'hF2, 2'd1);
    check(wr_cnt == 0, "R10 no write", wr_cnt, 0);
    limit = 16'h109; idle(1);

    clr();
    check(ovf_flag == 0, "R11 clear before", ovf_flag, 0);
    bv = 1; bfrom = 32'h11; bto = 32'h22; bpriv = 2'd1;
    @(negedge clk);
    bfrom = 32'h33; bto = 32'h44;
    @(negedge clk);
    bv = 0;
    idle(6);
    check(wr_cnt == 3 && ovf_flag == 1, "R11 drop and flag", {wr_cnt, ovf_flag}, {32'd3, 1'b1});

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule